// File: doc/BRIEF.md
# Effective Address Context Qualifier

This block sits in front of a two-level radix address translator. For each request it takes a 64-bit effective address, a hypervisor flag, a relocation-enable flag and an access type. It reads three context values: a partition register, a process register and a real-mode offset register. From these it decides which partition and process the access belongs to, and which translation stages the downstream walkers must run.

The top two address bits select a quadrant. Hypervisor and guest accesses use different maps from quadrant to partition and process. In guest mode two quadrants are illegal and raise a segment fault. A hypervisor access with relocation off skips translation completely. Its real address is formed directly from the effective address and the offset register.

Results are registered. They appear one cycle after a request strobe, together with a one-cycle valid pulse, and then hold until the next request. The walks, permission checks and interrupt delivery are done elsewhere.

Top module: `ea_ctx_qual`

## Requirements
- R1: In hypervisor mode with relocation on, the quadrant (address bits 63:62) selects the outputs as follows. Quadrant 0 gives partition 0 and the process register. Quadrant 1 gives the partition register and the process register. Quadrant 2 gives the partition register and process 0. Quadrant 3 gives partition 0 and process 0.
- R2: In guest mode, quadrant 0 gives the partition register and the process register, and quadrant 3 gives the partition register and process 0. This holds whether relocation is on or off.
- R3: In guest mode, quadrants 1 and 2 raise `out_fault`. In that case partition, process, both stage enables, the real flag, `out_raddr`, `out_perm` and `out_psize` are all zero.
- R4: The fault kind depends on the access type. A fetch (`req_acc`=00) reports kind 01 (instruction segment). A load (01) or store (10) reports kind 10 (data segment). A data segment fault loads the effective address into `out_fault_addr`. An instruction segment fault, and any access that does not fault, leaves `out_fault_addr` unchanged. No error code is produced.
- R5: A hypervisor access with relocation off is a bypass and sets `out_real`. `out_raddr` is the effective address with bits 63:60 cleared. The offset register is ORed in only when effective address bit 63 is 0.
- R6: A bypass grants `out_perm`=111 (bit 2 read, bit 1 write, bit 0 execute) and `out_psize`=12. Partition, process and both stage enables are 0.
- R7: For a legal access that is not a bypass, `out_stage1` equals the relocation flag. `out_raddr` is the effective address with bits 63:62 cleared. `out_perm` and `out_psize` are 0.
- R8: For a legal access that is not a bypass, `out_stage2` is 1 when the selected partition is nonzero or the access is a guest access. Otherwise it is 0.
- R9: `out_valid` pulses for exactly the cycle after each request cycle. Every other output changes only in that cycle and holds in all other cycles. Back-to-back requests give back-to-back results.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ea | input | 64 | Effective address |
| req_hv | input | 1 | Hypervisor privilege |
| req_reloc | input | 1 | Relocation enabled |
| req_acc | input | 2 | Access type: 00 fetch, 01 load, 10 store |
| part_reg | input | 12 | Current partition register |
| pid_reg | input | 20 | Current process register |
| rmo_reg | input | 64 | Real-mode offset register |
| out_valid | output | 1 | One-cycle result strobe |
| out_part | output | 12 | Qualified partition ID |
| out_pid | output | 20 | Qualified process ID |
| out_stage1 | output | 1 | Process-scoped walk required |
| out_stage2 | output | 1 | Partition-scoped walk required |
| out_real | output | 1 | Real-mode bypass taken |
| out_raddr | output | 64 | Bypass real address or walk input address |
| out_perm | output | 3 | Granted permission {read, write, execute} |
| out_psize | output | 7 | Page size as log2 bytes |
| out_fault | output | 1 | Segment fault |
| out_fault_kind | output | 2 | 00 none, 01 instruction segment, 10 data segment |
| out_fault_addr | output | 64 | Address of the last data segment fault |

## Verification
Because every output is registered, a wrong quadrant decode or stage decision shows up at the ports in the single cycle after the request. The bench compares every field there against a model it builds independently. A wrong update of the fault-address register can be hidden by a later data fault, so the bench sends instruction faults and legal accesses between data faults and checks that the address does not move. Idle cycles are checked on every cycle so that a hold failure is caught at once.

// File: rtl/ecq_pkg.sv
package ecq_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'b00,
      ACC_LOAD  = 2'b01,
      ACC_STORE = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_ISEG = 2'b01,
      FLT_DSEG = 2'b10,
      FLT_RSVD = 2'b11
   } flt_e;
endpackage

// File: rtl/ecq_quadrant_map.sv
module ecq_quadrant_map #(
   parameter int PARTW = 12,
   parameter int PIDW  = 20
) (
   input  logic             hv,
   input  logic [1:0]       quad,
   input  logic [PARTW-1:0] part_in,
   input  logic [PIDW-1:0]  pid_in,
   output logic [PARTW-1:0] part_sel,
   output logic [PIDW-1:0]  pid_sel,
   output logic             legal
);
   always_comb begin
      part_sel = '0;
      pid_sel  = '0;
      legal    = 1'b1;
      if (hv) begin
         unique case (quad)
            2'd0: pid_sel = pid_in;
            2'd1: begin part_sel = part_in; pid_sel = pid_in; end
            2'd2: part_sel = part_in;
            default: ;
         endcase
      end else begin
         unique case (quad)
            2'd0: begin part_sel = part_in; pid_sel = pid_in; end
            2'd3: part_sel = part_in;
            default: legal = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/ecq_real_bypass.sv
module ecq_real_bypass #(
   parameter int EAW       = 64,
   parameter int CLRW      = 4,
   parameter bit OR_OFFSET = 1'b1
) (
   input  logic [EAW-1:0] ea,
   input  logic [EAW-1:0] rmo,
   output logic [EAW-1:0] raddr
);
   localparam int KEEPW = EAW - CLRW;

   logic [EAW-1:0] cleared;

   for (genvar i = 0; i < EAW; i++) begin : g_bit
      if (i < KEEPW) begin : g_keep
         assign cleared[i] = ea[i];
      end else begin : g_zero
         assign cleared[i] = 1'b0;
      end
   end

   if (OR_OFFSET) begin : g_or
      assign raddr = ea[EAW-1] ? cleared : (cleared | rmo);
   end else begin : g_plain
      logic unused_rmo;
      assign unused_rmo = ^rmo;
      assign raddr = cleared;
   end
endmodule

// File: rtl/ecq_stage_sel.sv
module ecq_stage_sel #(
   parameter int PARTW = 12
) (
   input  logic             hv,
   input  logic             reloc,
   input  logic             legal,
   input  logic [PARTW-1:0] part_sel,
   output logic             bypass,
   output logic             fault,
   output logic             stage1,
   output logic             stage2
);
   always_comb begin
      bypass = hv & ~reloc;
      fault  = ~bypass & ~legal;
      stage1 = ~bypass & legal & reloc;
      stage2 = ~bypass & legal & ((|part_sel) | ~hv);
   end
endmodule

// File: rtl/ea_ctx_qual.sv
module ea_ctx_qual
   import ecq_pkg::*;
#(
   parameter int EAW        = 64,
   parameter int PARTW      = 12,
   parameter int PIDW       = 20,
   parameter int PAGE_BITS  = 12,
   parameter int REAL_CLRW  = 4,
   parameter bit OR_OFFSET  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [EAW-1:0]   req_ea,
   input  logic             req_hv,
   input  logic             req_reloc,
   input  logic [1:0]       req_acc,
   input  logic [PARTW-1:0] part_reg,
   input  logic [PIDW-1:0]  pid_reg,
   input  logic [EAW-1:0]   rmo_reg,
   output logic             out_valid,
   output logic [PARTW-1:0] out_part,
   output logic [PIDW-1:0]  out_pid,
   output logic             out_stage1,
   output logic             out_stage2,
   output logic             out_real,
   output logic [EAW-1:0]   out_raddr,
   output logic [2:0]       out_perm,
   output logic [$clog2(EAW+1)-1:0] out_psize,
   output logic             out_fault,
   output logic [1:0]       out_fault_kind,
   output logic [EAW-1:0]   out_fault_addr
);
   localparam int PSW   = $clog2(EAW + 1);
   localparam int QUADW = 2;
   localparam logic [EAW-1:0] WALK_MASK = {EAW{1'b1}} >> QUADW;

   if (EAW < 8) begin : g_chk_eaw
      $error("ea_ctx_qual: EAW too small");
   end
   if (REAL_CLRW < QUADW || REAL_CLRW >= EAW) begin : g_chk_clr
      $error("ea_ctx_qual: REAL_CLRW out of range");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= EAW) begin : g_chk_page
      $error("ea_ctx_qual: PAGE_BITS out of range");
   end
   if (PARTW < 1 || PIDW < 1) begin : g_chk_ids
      $error("ea_ctx_qual: ID widths must be positive");
   end

   logic [PARTW-1:0] part_sel;
   logic [PIDW-1:0]  pid_sel;
   logic             legal, bypass, fault, stage1, stage2;
   logic [EAW-1:0]   real_addr;

   ecq_quadrant_map #(.PARTW(PARTW), .PIDW(PIDW)) u_qmap (
      .hv       (req_hv),
      .quad     (req_ea[EAW-1 -: QUADW]),
      .part_in  (part_reg),
      .pid_in   (pid_reg),
      .part_sel (part_sel),
      .pid_sel  (pid_sel),
      .legal    (legal)
   );

   ecq_real_bypass #(.EAW(EAW), .CLRW(REAL_CLRW), .OR_OFFSET(OR_OFFSET)) u_rbyp (
      .ea    (req_ea),
      .rmo   (rmo_reg),
      .raddr (real_addr)
   );

   ecq_stage_sel #(.PARTW(PARTW)) u_ssel (
      .hv       (req_hv),
      .reloc    (req_reloc),
      .legal    (legal),
      .part_sel (part_sel),
      .bypass   (bypass),
      .fault    (fault),
      .stage1   (stage1),
      .stage2   (stage2)
   );

   acc_e acc;
   assign acc = acc_e'(req_acc);

   logic data_fault;
   assign data_fault = fault & (acc != ACC_FETCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_part       <= '0;
         out_pid        <= '0;
         out_stage1     <= 1'b0;
         out_stage2     <= 1'b0;
         out_real       <= 1'b0;
         out_raddr      <= '0;
         out_perm       <= '0;
         out_psize      <= '0;
         out_fault      <= 1'b0;
         out_fault_kind <= FLT_NONE;
         out_fault_addr <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_fault  <= fault;
            out_real   <= bypass;
            out_stage1 <= stage1;
            out_stage2 <= stage2;
            out_part   <= (bypass | fault) ? '0 : part_sel;
            out_pid    <= (bypass | fault) ? '0 : pid_sel;
            if (bypass) begin
               out_raddr <= real_addr;
               out_perm  <= 3'b111;
               out_psize <= PSW'(PAGE_BITS);
            end else begin
               out_raddr <= fault ? '0 : (req_ea & WALK_MASK);
               out_perm  <= '0;
               out_psize <= '0;
            end
            if (!fault) out_fault_kind <= FLT_NONE;
            else if (acc == ACC_FETCH) out_fault_kind <= FLT_ISEG;
            else out_fault_kind <= FLT_DSEG;
            if (data_fault) out_fault_addr <= req_ea;
         end
      end
   end
endmodule

// File: rtl/ecq_chk.sv
module ecq_chk #(
   parameter int EAW       = 64,
   parameter int PARTW     = 12,
   parameter int PAGE_BITS = 12,
   parameter int REAL_CLRW = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [EAW-1:0]   req_ea,
   input logic             req_hv,
   input logic             req_reloc,
   input logic [1:0]       req_acc,
   input logic             out_valid,
   input logic [PARTW-1:0] out_part,
   input logic             out_stage1,
   input logic             out_stage2,
   input logic             out_real,
   input logic [EAW-1:0]   out_raddr,
   input logic [2:0]       out_perm,
   input logic [$clog2(EAW+1)-1:0] out_psize,
   input logic             out_fault,
   input logic [1:0]       out_fault_kind,
   input logic [EAW-1:0]   out_fault_addr
);
   localparam int PSW = $clog2(EAW + 1);
   localparam logic [EAW-1:0] KEEP = {EAW{1'b1}} >> REAL_CLRW;

   logic guest_bad;
   assign guest_bad = req_valid && !req_hv &&
                      (req_ea[EAW-1 -: 2] == 2'd1 || req_ea[EAW-1 -: 2] == 2'd2);

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(out_part) && $stable(out_raddr) && $stable(out_fault));
   a_r3_guest_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      guest_bad |=> out_fault && !out_stage1 && !out_stage2 && !out_real);
   a_r4_dseg_addr: assert property (@(posedge clk) disable iff (!rst_n)
      guest_bad && req_acc != 2'b00 |=> out_fault_kind == 2'b10 && out_fault_addr == $past(req_ea));
   a_r4_iseg_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      guest_bad && req_acc == 2'b00 |=> out_fault_kind == 2'b01 && $stable(out_fault_addr));
   a_r6_bypass_grant: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_hv && !req_reloc |=> out_real && out_perm == 3'b111 && out_psize == PSW'(PAGE_BITS));
   a_r5_high_half: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_hv && !req_reloc && req_ea[EAW-1] |=> out_raddr == ($past(req_ea) & KEEP));
   a_r8_part_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_fault && !out_real && (out_part != '0) |-> out_stage2);
   a_r7_reloc_stage1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_reloc && !guest_bad |=> out_stage1);
endmodule

bind ea_ctx_qual ecq_chk #(
   .EAW(EAW), .PARTW(PARTW), .PAGE_BITS(PAGE_BITS), .REAL_CLRW(REAL_CLRW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
   .req_hv(req_hv), .req_reloc(req_reloc), .req_acc(req_acc),
   .out_valid(out_valid), .out_part(out_part), .out_stage1(out_stage1),
   .out_stage2(out_stage2), .out_real(out_real), .out_raddr(out_raddr),
   .out_perm(out_perm), .out_psize(out_psize), .out_fault(out_fault),
   .out_fault_kind(out_fault_kind), .out_fault_addr(out_fault_addr)
);

// File: tb/sim_ea_ctx_qual.sv
module sim_ea_ctx_qual;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_ea = '0;
   logic        req_hv = 1'b0;
   logic        req_reloc = 1'b0;
   logic [1:0]  req_acc = 2'b00;
   logic [11:0] part_reg = 12'h000;
   logic [19:0] pid_reg = 20'h00000;
   logic [63:0] rmo_reg = '0;
   logic        out_valid, out_stage1, out_stage2, out_real, out_fault;
   logic [11:0] out_part;
   logic [19:0] out_pid;
   logic [63:0] out_raddr, out_fault_addr;
   logic [2:0]  out_perm;
   logic [6:0]  out_psize;
   logic [1:0]  out_fault_kind;

   always #4 clk = ~clk;

   ea_ctx_qual u0 (.*);

   typedef struct packed {
      logic        fault;
      logic [1:0]  fk;
      logic [63:0] fa;
      logic [11:0] part;
      logic [19:0] pid;
      logic        s1, s2, rl;
      logic [63:0] ra;
      logic [2:0]  perm;
      logic [6:0]  ps;
   } exp_t;

   exp_t        sb[$];
   exp_t        last;
   logic        have_last = 1'b0;
   logic [63:0] model_fa = '0;
   int          total = 0, bad = 0;
   logic        done = 1'b0;

   task automatic chk(string r, string f, logic [63:0] a, logic [63:0] e);
      total++;
      if (a !== e) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", r, f, a, e);
      end
   endtask

   function automatic exp_t model(logic [63:0] ea, logic hv, logic rel, logic [1:0] acc);
      exp_t x;
      logic ok;
      x = '0;
      x.fa = model_fa;
      if (hv && !rel) begin
         x.rl = 1'b1;
         x.ra = {4'h0, ea[59:0]} | (ea[63] ? 64'h0 : rmo_reg);
         x.perm = 3'b111;
         x.ps = 7'd12;
         return x;
      end
      ok = 1'b1;
      case ({hv, ea[63:62]})
         3'b100: x.pid = pid_reg;
         3'b101: begin x.part = part_reg; x.pid = pid_reg; end
         3'b110: x.part = part_reg;
         3'b111: ;
         3'b000: begin x.part = part_reg; x.pid = pid_reg; end
         3'b011: x.part = part_reg;
         default: ok = 1'b0;
      endcase
      if (!ok) begin
         x.fault = 1'b1;
         x.fk = (acc == 2'b00) ? 2'b01 : 2'b10;
         if (acc != 2'b00) x.fa = ea;
      end else begin
         x.s1 = rel;
         x.s2 = (x.part != 12'h0) || !hv;
         x.ra = {2'b00, ea[61:0]};
      end
      return x;
   endfunction

   task automatic send(logic [63:0] ea, logic hv, logic rel, logic [1:0] acc);
      exp_t x;
      @(negedge clk);
      req_valid = 1'b1; req_ea = ea; req_hv = hv; req_reloc = rel; req_acc = acc;
      x = model(ea, hv, rel, acc);
      model_fa = x.fa;
      sb.push_back(x);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (sb.size() == 0) begin
               chk("R9", "unexpected valid", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk("R3", "fault", 64'(out_fault), 64'(e.fault));
               chk("R4", "fault_kind", 64'(out_fault_kind), 64'(e.fk));
               chk("R4", "fault_addr", out_fault_addr, e.fa);
               chk("R1 R2", "part", 64'(out_part), 64'(e.part));
               chk("R1 R2", "pid", 64'(out_pid), 64'(e.pid));
               chk("R7", "stage1", 64'(out_stage1), 64'(e.s1));
               chk("R8", "stage2", 64'(out_stage2), 64'(e.s2));
               chk("R5", "real", 64'(out_real), 64'(e.rl));
               chk("R5 R7", "raddr", out_raddr, e.ra);
               chk("R6", "perm", 64'(out_perm), 64'(e.perm));
               chk("R6", "psize", 64'(out_psize), 64'(e.ps));
               last = e;
               have_last = 1'b1;
            end
         end else if (have_last) begin
            chk("R9", "hold part", 64'(out_part), 64'(last.part));
            chk("R9", "hold raddr", out_raddr, last.ra);
            chk("R9", "hold fault_addr", out_fault_addr, last.fa);
         end
      end
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         bad++; total++;
         $display("FAIL watchdog R9 actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      part_reg = 12'h5a3; pid_reg = 20'h0c0de; rmo_reg = 64'h0000_0000_4000_0000;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10", "valid", 64'(out_valid), 64'd0);
      chk("R10", "fault", 64'(out_fault), 64'd0);
      chk("R10", "part", 64'(out_part), 64'd0);
      chk("R10", "raddr", out_raddr, 64'd0);
      chk("R10", "fault_addr", out_fault_addr, 64'd0);
      rst_n = 1'b1;
      idle(2);
      // R1 hypervisor quadrants, relocation on
      send(64'h0123_4567_89ab_cdef, 1, 1, 2'b01);
      send(64'h4123_4567_89ab_cdef, 1, 1, 2'b10); idle(1);
      send(64'h8000_0000_0000_1000, 1, 1, 2'b00); idle(2);
      send(64'hc000_0000_dead_0000, 1, 1, 2'b01); idle(1);
      // R2 guest legal quadrants, relocation on and off
      send(64'h0000_0000_0000_2000, 0, 1, 2'b01);
      send(64'hffff_ffff_ffff_f000, 0, 1, 2'b00);
      send(64'h0000_1234_0000_0000, 0, 0, 2'b10);
      send(64'hc000_0000_0000_0008, 0, 0, 2'b01); idle(2);
      // R3 R4 guest illegal quadrants
      send(64'h4000_0000_0000_aaaa, 0, 1, 2'b01); idle(1);
      send(64'h8000_0000_0000_bbbb, 0, 1, 2'b00); idle(2);
      send(64'h0000_0000_0000_3000, 0, 1, 2'b01); idle(1);
      send(64'h8000_0000_0000_cccc, 0, 0, 2'b10); idle(1);
      send(64'h4000_0000_0000_dddd, 0, 1, 2'b00); idle(2);
      // R5 R6 real-mode bypass
      send(64'h1234_5678_0000_0100, 1, 0, 2'b01); idle(1);
      send(64'hf234_5678_0000_0100, 1, 0, 2'b00); idle(1);
      send(64'h7fff_ffff_ffff_ffff, 1, 0, 2'b10); idle(1);
      send(64'h8000_0000_0000_0000, 1, 0, 2'b01); idle(1);
      // R8 hypervisor access with zero partition register
      part_reg = 12'h000;
      send(64'h4000_0000_0000_4000, 1, 1, 2'b01);
      send(64'h4000_0000_0000_5000, 0, 1, 2'b01);
      send(64'h0000_0000_0000_6000, 1, 1, 2'b01); idle(3);
      if (sb.size() != 0) chk("R9", "pending results", 64'(sb.size()), 64'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule